// File: doc/BRIEF.md
# Manchester II Line Encoder with Command Sync

This block turns a serial NRZ bit stream into a Manchester II coded line carried on a pair of complementary outputs. A transmit-gate input, `cts_i`, controls it. While the gate is high the encoder is held off: both line outputs rest high and the bit clock output stays low. When the gate falls, a frame starts. A command synchronization pulse goes out first, and NRZ data bits follow it back to back until the gate rises again.

The upstream logic shifts data in on the block's own 1X bit clock, `bit_clk_o`. On the clock edge at which `bit_clk_o` falls, the encoder takes the level of `nrz_i`, and that bit fills the bit slot that begins at the same edge. The bit time is 16 or 32 system clock cycles, selected by `rate_sel_i`. The rate is captured once, when a frame starts.

Top module: `mnch_encoder`

## Requirements
- R1: At any clock edge where `cts_i` is 1, the outputs become idle after that edge and stay idle while it remains 1. Idle means `line_pos_o`=1, `line_neg_o`=1 and `bit_clk_o`=0. Changes on `nrz_i` have no effect while idle.
- R2: A high-to-low change of `cts_i`, seen at clock edge E, starts a frame at E. The command sync then follows. `line_pos_o` is 1 for three half-bit times, then `line_pos_o` is 0 for three half-bit times.
- R3: While `rst_n` is 0, the outputs are idle. If `cts_i` is already 0 when reset is released, with no falling edge after release, no frame starts and the outputs stay idle.
- R4: Data slots follow the sync with no gap, each one bit time long. In a slot, a 1 drives `line_pos_o` high for the first half and low for the second half. A 0 drives `line_pos_o` low, then high.
- R5: During a frame, `line_neg_o` is the complement of `line_pos_o`. The two outputs are never both 0.
- R6: With `rate_sel_i`=1, a half-bit lasts 16 clock cycles (bit time 32). With `rate_sel_i`=0, a half-bit lasts 8 cycles (bit time 16).
- R7: `rate_sel_i` is sampled only at the edge that starts a frame. Changes to it during the frame have no effect on that frame's timing.
- R8: `bit_clk_o` is 0 during the first five half-bits of the sync and 1 during the sixth. In every data slot it is 0 in the first half and 1 in the second. It therefore falls exactly at the start of each data slot.
- R9: The bit sent in a data slot is the level of `nrz_i` just before the clock edge that begins the slot, which is the edge at which `bit_clk_o` falls. The level of `nrz_i` at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_i | input | 1 | Transmit gate: 1 holds the encoder off, and a falling edge starts a frame |
| rate_sel_i | input | 1 | Bit time select: 1 gives 32 clocks, 0 gives 16 |
| nrz_i | input | 1 | Serial NRZ data, sampled where `bit_clk_o` falls |
| bit_clk_o | output | 1 | 1X bit clock for the upstream data source |
| line_pos_o | output | 1 | Manchester line output, true polarity |
| line_neg_o | output | 1 | Manchester line output, complement polarity |

## Verification
The assertions assume that `cts_i`, `rate_sel_i` and `nrz_i` are synchronous to `clk` and that `rst_n` is held low for at least one clock edge. The bench meets both conditions: it drives every input on the falling clock edge and asserts reset for several cycles. The data input is set to the complement of the intended bit on every cycle except the one just before a capture edge. This places the capture instant exactly, while `rate_sel_i` is deliberately toggled inside some frames.

// File: rtl/mnch_pkg.sv
package mnch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SYNC = 2'd1,
    ST_DATA = 2'd2
  } tx_state_e;

  // sync: three half-bits high on the true output, three low
  localparam int unsigned SYNC_HALVES    = 6;
  localparam int unsigned SYNC_HI_HALVES = 3;
  localparam int unsigned IDX_W          = 3;

endpackage

// File: rtl/mnch_halfbit_timer.sv
module mnch_halfbit_timer #(
  parameter int unsigned DIV_FAST = 16,
  parameter int unsigned DIV_SLOW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic rate_sel_i,
  output logic half_end_o
);

  localparam int unsigned HALF_FAST = DIV_FAST / 2;
  localparam int unsigned HALF_SLOW = DIV_SLOW / 2;
  localparam int unsigned CNT_W     = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;

  logic             rate_q, rate_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    last_cnt   = rate_q ? CNT_W'(HALF_SLOW - 1) : CNT_W'(HALF_FAST - 1);
    half_end_o = run_i && (cnt_q == last_cnt);
  end

  always_comb begin
    rate_d = rate_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      rate_d = rate_sel_i;
      cnt_d  = '0;
    end else if (run_i) begin
      cnt_d = half_end_o ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt); // R6

  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i) |=> $stable(rate_q)); // R7

endmodule

// File: rtl/mnch_frame_seq.sv
module mnch_frame_seq
  import mnch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_i,
  input  logic             nrz_i,
  input  logic             half_end_i,
  output tx_state_e        state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             bit_o,
  output logic             start_o,
  output logic             run_o
);

  localparam logic [IDX_W-1:0] LAST_SYNC = IDX_W'(SYNC_HALVES - 1);

  tx_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bit_q, bit_d;
  logic             cts_q;

  always_comb begin
    start_o = cts_q && !cts_i;
    run_o   = (st_q != ST_IDLE);
  end

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    bit_d = bit_q;
    if (cts_i) begin
      st_d  = ST_IDLE;
      idx_d = '0;
    end else if (start_o) begin
      st_d  = ST_SYNC;
      idx_d = '0;
    end else if (half_end_i) begin
      unique case (st_q)
        ST_SYNC: begin
          if (idx_q == LAST_SYNC) begin
            st_d  = ST_DATA;
            idx_d = '0;
            bit_d = nrz_i;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (idx_q[0]) begin
            idx_d = '0;
            bit_d = nrz_i;
          end else begin
            idx_d = IDX_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      bit_q <= 1'b0;
      cts_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      bit_q <= bit_d;
      cts_q <= cts_i;
    end
  end

  assign state_o = st_q;
  assign idx_o   = idx_q;
  assign bit_o   = bit_q;

  AST_START_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (st_q == ST_SYNC && idx_q == '0)); // R2

  AST_GATE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cts_i |=> (st_q == ST_IDLE)); // R1

  AST_DATA_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (idx_q <= IDX_W'(1))); // R4

endmodule

// File: rtl/mnch_line_drv.sv
module mnch_line_drv
  import mnch_pkg::*;
(
  input  tx_state_e        state_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  output logic             pos_o,
  output logic             neg_o,
  output logic             bclk_o
);

  localparam logic [IDX_W-1:0] LAST_SYNC = IDX_W'(SYNC_HALVES - 1);
  localparam logic [IDX_W-1:0] HI_END    = IDX_W'(SYNC_HI_HALVES);

  logic pos_t;

  always_comb begin
    pos_t  = 1'b1;
    neg_o  = 1'b1;
    bclk_o = 1'b0;
    unique case (state_i)
      ST_SYNC: begin
        pos_t  = (idx_i < HI_END);
        neg_o  = ~pos_t;
        bclk_o = (idx_i == LAST_SYNC);
      end
      ST_DATA: begin
        pos_t  = idx_i[0] ? ~bit_i : bit_i;
        neg_o  = ~pos_t;
        bclk_o = idx_i[0];
      end
      default: ;
    endcase
    pos_o = pos_t;
  end

endmodule

// File: rtl/mnch_encoder.sv
module mnch_encoder
  import mnch_pkg::*;
#(
  parameter int unsigned DIV_FAST = 16,
  parameter int unsigned DIV_SLOW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_i,
  input  logic rate_sel_i,
  input  logic nrz_i,
  output logic bit_clk_o,
  output logic line_pos_o,
  output logic line_neg_o
);

  localparam logic [IDX_W-1:0] LAST_SYNC = IDX_W'(SYNC_HALVES - 1);

  tx_state_e        state;
  logic [IDX_W-1:0] idx;
  logic             cur_bit;
  logic             start;
  logic             run;
  logic             half_end;

  mnch_halfbit_timer #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .run_i      (run),
    .rate_sel_i (rate_sel_i),
    .half_end_o (half_end)
  );

  mnch_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_i      (cts_i),
    .nrz_i      (nrz_i),
    .half_end_i (half_end),
    .state_o    (state),
    .idx_o      (idx),
    .bit_o      (cur_bit),
    .start_o    (start),
    .run_o      (run)
  );

  mnch_line_drv u_drv (
    .state_i (state),
    .idx_i   (idx),
    .bit_i   (cur_bit),
    .pos_o   (line_pos_o),
    .neg_o   (line_neg_o),
    .bclk_o  (bit_clk_o)
  );

  AST_IDLE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cts_i) |-> (line_pos_o && line_neg_o && !bit_clk_o)); // R1

  AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pos_o || line_neg_o)); // R5

  AST_SYNC_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC && idx != LAST_SYNC) |-> !bit_clk_o); // R8

endmodule

// File: tb/sim_mnch_encoder.sv
module sim_mnch_encoder;

  logic clk;
  logic rst_n;
  logic cts_i;
  logic rate_sel_i;
  logic nrz_i;
  logic bit_clk_o;
  logic line_pos_o;
  logic line_neg_o;

  int checks;
  int errors;

  mnch_encoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_i      (cts_i),
    .rate_sel_i (rate_sel_i),
    .nrz_i      (nrz_i),
    .bit_clk_o  (bit_clk_o),
    .line_pos_o (line_pos_o),
    .line_neg_o (line_neg_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // compares {bit_clk, pos, neg}
  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {bit_clk_o, line_pos_o, line_neg_o};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t got clk/pos/neg=%b expected %b", req, $time, got, exp);
    end
  endtask

  // one frame of eight bits; the edge that starts it is index 0
  task automatic run_frame(input logic rate, input logic [7:0] word, input logic wiggle_rate);
    int h;
    int total;
    @(negedge clk);
    cts_i      = 1'b1;
    rate_sel_i = rate;
    nrz_i      = ~word[0];
    repeat (3) @(negedge clk);
    chk("R1 idle before frame", 3'b011);
    h     = rate ? 16 : 8;
    total = 6 * h + 16 * h;
    cts_i = 1'b0;
    for (int k = 0; k < total; k++) begin
      logic [2:0] e;
      int m;
      int jn;
      @(negedge clk);
      if (k < 3 * h) begin
        e = 3'b010;
        chk("R2 R6 sync high part", e);
      end else if (k < 6 * h) begin
        e = (k >= 5 * h) ? 3'b101 : 3'b001;
        chk("R2 R8 sync low part", e);
      end else begin
        int j;
        int hh;
        logic p;
        j  = (k - 6 * h) / (2 * h);
        hh = ((k - 6 * h) / h) % 2;
        p  = (hh == 0) ? word[j] : ~word[j];
        e  = {hh == 1, p, ~p};
        chk("R4 R5 R8 R9 data slot", e);
      end
      if (wiggle_rate && (k % 5 == 2)) rate_sel_i = ~rate_sel_i; // R7
      if (k + 1 <= 6 * h) m = 6 * h;
      else m = 6 * h + 2 * h * ((k + 1 - 6 * h + 2 * h - 1) / (2 * h));
      jn = (m - 6 * h) / (2 * h);
      if (jn < 8) nrz_i = (m == k + 1) ? word[jn] : ~word[jn];
      else nrz_i = ~nrz_i;
      if (k == total - 1) cts_i = 1'b1;
    end
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      nrz_i = ~nrz_i;
      chk("R1 idle after gate rises", 3'b011);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks     = 0;
    errors     = 0;
    rst_n      = 1'b0;
    cts_i      = 1'b0;
    rate_sel_i = 1'b0;
    nrz_i      = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 idle in reset", 3'b011);
    rst_n = 1'b1;
    for (int q = 0; q < 40; q++) begin
      @(negedge clk);
      nrz_i = ~nrz_i;
      chk("R3 no frame without falling gate", 3'b011);
    end

    for (int r = 0; r < 2; r++) begin
      for (int w = 0; w < 16; w++) begin
        logic [3:0] n;
        n = 4'(w);
        run_frame(r[0], {n, n ^ 4'hA}, 1'b0);
      end
    end

    run_frame(1'b0, 8'hA5, 1'b1); // R7
    run_frame(1'b1, 8'h3C, 1'b1); // R7

    // abort in mid-sync, then hold the gate high
    @(negedge clk);
    cts_i = 1'b1;
    repeat (2) @(negedge clk);
    cts_i = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 sync high before abort", 3'b010);
    cts_i = 1'b1;
    for (int q = 0; q < 60; q++) begin
      @(negedge clk);
      nrz_i = ~nrz_i;
      chk("R1 abort forces idle", 3'b011);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule